// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item Copier

This block serves a small set of read-only configuration items to a host and can move them into system memory by itself. The host picks an item with a selector register. It can then pull the item out one byte at a time through a data register, or it can hand the block the address of a 16-byte job descriptor in memory. A write of that descriptor address starts a job at once. The engine reads the descriptor over a byte-wide memory master port. It copies the requested number of item bytes, taken from the current item offset, to the target address, and then writes the updated descriptor back to memory.

A target address of zero turns the copy into a skip. No memory write is made, but the item offset moves forward as if the bytes had been copied. The descriptor keeps a running target address and remaining length, so after an error the written-back fields show how far the copy got. Software polls a status register until the busy bit clears, then reads the descriptor's control word: 0 means success and bit 0 set means failure.

The memory master uses valid/ready handshakes. A request (`mem_req_*`) is transferred on a cycle where valid and ready are both high. While valid is high and ready is low, the request holds its address, direction and data. A read response is taken only in a cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high, and the engine keeps at most one read outstanding. The host port is a plain strobe interface: one access per cycle, with read data returned one cycle later.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset the status register (host address 0x12, bit 0 = busy) reads 0, no memory request is issued, the selected item is 0 and the item offset is 0.
- R2: A host write to address 0x08 selects item `host_wdata[15:0]` and clears the offset. A host read of address 0x00 returns the item byte at the offset in `host_rdata[7:0]` (upper bits 0) and advances the offset by 1. At or past the item end it returns 0 and does not advance. `host_rvalid` and `host_rdata` follow a read strobe by exactly one cycle. Item s < 4 is 8·(s+1) bytes long and holds byte (16·s + 3·k + 1) mod 256 at offset k. Any other item is empty.
- R3: A host write to address 0x0A while idle starts a job with descriptor pointer P. Byte lane j of `host_wdata` is byte j of P in big-endian order, so lane 0 is the most significant. Busy reads 1 from the next cycle until the write-back is complete.
- R4: The engine reads the descriptor as 16 single-byte reads at P..P+15, one at a time. Bytes 0–7 are the target address, 8–11 the length and 12–15 the control word, each most-significant byte first.
- R5: With control 2 and a nonzero target, the engine writes the item bytes, starting at the current offset, to ascending addresses from the target. Nothing is written beyond the last copied byte.
- R6: With control 2 and target 0, no data write is issued, yet the offset still advances by the number of bytes covered.
- R7: On success the engine writes back the target address advanced by the bytes copied (still 0 for a skip), a length of 0 and a control word of 0. These go to P..P+15 in the same big-endian layout.
- R8: A control value other than 2 fails at once: the control word becomes 1, the address and length are written back unchanged, no data is written and the offset does not move.
- R9: A read that reaches the item end stops there. The bytes before the end are copied, the control word becomes 1, and the address and length show exactly the progress made.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with stable address, direction and data. `mem_rsp_ready` is high only while a read is outstanding and never together with `mem_req_valid`.
- R11: While busy, host writes are ignored, so neither the selector nor a new job is accepted. Data reads return 0 without advancing the offset.
- R12: A read job with length 0 succeeds without a data write and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 5 | Host register byte address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, one cycle after the strobe |
| host_rvalid | output | 1 | Marks host_rdata as valid |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | 64 | Memory byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Engine can take the read response |
| mem_rsp_data | input | 8 | Read response byte |

## Verification
Host read data is due one cycle after the read strobe. The bench drives strobes on falling edges and samples on the next falling edge, which falls inside that cycle. Busy is registered by the edge that takes the descriptor-address write, so a status poll issued right after the write already sees it. Job results are not tied to a fixed cycle count, because back-pressure stretches every handshake. The bench instead polls status until busy clears, then inspects memory, the write count and the next data byte. The request-hold rule is watched on every edge by a monitor that compares each stalled request with the request in the following cycle.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam logic [4:0] RA_DATA = 5'h00;
  localparam logic [4:0] RA_SEL  = 5'h08;
  localparam logic [4:0] RA_PTR  = 5'h0A;
  localparam logic [4:0] RA_STAT = 5'h12;

  localparam logic [31:0] CTL_READ = 32'd2;
  localparam logic [31:0] CTL_ERR  = 32'd1;
  localparam logic [31:0] CTL_OK   = 32'd0;

  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    X_IDLE, X_FETCH, X_FWAIT, X_DECIDE, X_MOVE, X_WBACK
  } xfer_state_t;
endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom #(
  parameter int N_ITEMS  = 4,
  parameter int LEN_STEP = 8,
  parameter int SEL_W    = 16,
  parameter int OFF_W    = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [OFF_W-1:0] off,
  output logic [OFF_W-1:0] item_len,
  output logic [7:0]       item_byte,
  output logic             in_range
);
  localparam int IDX_W = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1;

  logic [OFF_W-1:0] len_tab [N_ITEMS];

  for (genvar g = 0; g < N_ITEMS; g++) begin : g_len
    assign len_tab[g] = OFF_W'(LEN_STEP * (g + 1));
  end

  assign item_len  = (sel < SEL_W'(N_ITEMS)) ? len_tab[sel[IDX_W-1:0]] : '0;
  assign item_byte = {sel[3:0], 4'b0000} + 8'(off[7:0] * 8'd3) + 8'd1;
  assign in_range  = off < item_len;
endmodule

// File: rtl/cfg_item_cursor.sv
module cfg_item_cursor #(
  parameter int SEL_W = 16,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] load_sel,
  input  logic             adv,
  output logic [SEL_W-1:0] sel,
  output logic [OFF_W-1:0] off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      off <= '0;
    end else if (load) begin
      sel <= load_sel;
      off <= '0;
    end else if (adv) begin
      off <= off + OFF_W'(1);
    end
  end
endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_dma_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [4:0]       host_addr,
  input  logic [63:0]      host_wdata,
  input  logic             busy,
  input  logic [7:0]       cur_byte,
  input  logic             cur_valid,
  output logic             sel_load,
  output logic [SEL_W-1:0] sel_value,
  output logic             adv,
  output logic             start,
  output logic [63:0]      start_ptr,
  output logic [63:0]      host_rdata,
  output logic             host_rvalid
);
  logic        wr_ok;
  logic        data_rd;
  logic [63:0] rd_next;

  assign wr_ok     = host_we && !busy;
  assign sel_load  = wr_ok && (host_addr == RA_SEL);
  assign start     = wr_ok && (host_addr == RA_PTR);
  assign sel_value = host_wdata[SEL_W-1:0];

  // lane 0 carries the most significant pointer byte
  for (genvar g = 0; g < 8; g++) begin : g_swap
    assign start_ptr[63-8*g -: 8] = host_wdata[8*g +: 8];
  end

  assign data_rd = host_re && (host_addr == RA_DATA) && !busy && cur_valid;
  assign adv     = data_rd;

  always_comb begin
    case (host_addr)
      RA_DATA: rd_next = data_rd ? {56'b0, cur_byte} : 64'b0;
      RA_STAT: rd_next = {63'b0, busy};
      default: rd_next = 64'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_re;
      if (host_re) host_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_dma_xfer.sv
module cfg_dma_xfer
  import cfg_dma_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      start_ptr,
  input  logic [OFF_W-1:0] item_len,
  input  logic [OFF_W-1:0] cur_off,
  input  logic [7:0]       item_byte,
  output logic             adv,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [63:0]      mem_req_addr,
  output logic [7:0]       mem_req_wdata,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [7:0]       mem_rsp_data
);
  localparam int IDX_W = $clog2(DESC_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_BYTES - 1);

  xfer_state_t      state;
  logic [63:0]      ptr;
  logic [IDX_W-1:0] idx;
  logic [127:0]     job;   // {target, length, control}, big-endian order
  logic [63:0]      run_addr;
  logic [31:0]      run_len;
  logic [31:0]      run_ctl;
  logic             exhausted;
  logic [63:0]      desc_addr;

  assign run_addr  = job[127:64];
  assign run_len   = job[63:32];
  assign run_ctl   = job[31:0];
  assign exhausted = cur_off >= item_len;
  assign desc_addr = ptr + {{(64-IDX_W){1'b0}}, idx};
  assign busy      = state != X_IDLE;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    mem_rsp_ready = 1'b0;
    adv           = 1'b0;
    case (state)
      X_FETCH: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_addr;
      end
      X_FWAIT: mem_rsp_ready = 1'b1;
      X_MOVE: begin
        if (run_len != 32'd0 && !exhausted) begin
          if (run_addr == 64'd0) begin
            adv = 1'b1;
          end else begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = run_addr;
            mem_req_wdata = item_byte;
            adv           = mem_req_ready;
          end
        end
      end
      X_WBACK: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = desc_addr;
        mem_req_wdata = job[127:120];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= X_IDLE;
      ptr   <= '0;
      idx   <= '0;
      job   <= '0;
    end else begin
      case (state)
        X_IDLE: if (start) begin
          ptr   <= start_ptr;
          idx   <= '0;
          state <= X_FETCH;
        end
        X_FETCH: if (mem_req_ready) state <= X_FWAIT;
        X_FWAIT: if (mem_rsp_valid) begin
          job   <= {job[119:0], mem_rsp_data};
          idx   <= idx + IDX_W'(1);
          state <= (idx == IDX_LAST) ? X_DECIDE : X_FETCH;
        end
        X_DECIDE: begin
          if (run_ctl != CTL_READ) begin
            job[31:0] <= CTL_ERR;
            state     <= X_WBACK;
          end else begin
            state <= X_MOVE;
          end
        end
        X_MOVE: begin
          if (run_len == 32'd0) begin
            job[31:0] <= CTL_OK;
            state     <= X_WBACK;
          end else if (exhausted) begin
            job[31:0] <= CTL_ERR;
            state     <= X_WBACK;
          end else if (run_addr == 64'd0) begin
            job[63:32] <= run_len - 32'd1;
          end else if (mem_req_ready) begin
            job[127:64] <= run_addr + 64'd1;
            job[63:32]  <= run_len - 32'd1;
          end
        end
        X_WBACK: if (mem_req_ready) begin
          job <= {job[119:0], job[127:120]};
          idx <= idx + IDX_W'(1);
          if (idx == IDX_LAST) state <= X_IDLE;
        end
        default: state <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int N_ITEMS  = 4,
  parameter int LEN_STEP = 8,
  parameter int SEL_W    = 16,
  parameter int OFF_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [4:0]  host_addr,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic        host_rvalid,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [63:0] mem_req_addr,
  output logic [7:0]  mem_req_wdata,
  input  logic        mem_rsp_valid,
  output logic        mem_rsp_ready,
  input  logic [7:0]  mem_rsp_data
);
  logic [SEL_W-1:0] cur_sel;
  logic [OFF_W-1:0] cur_off;
  logic [OFF_W-1:0] item_len;
  logic [7:0]       item_byte;
  logic             cur_valid;
  logic             sel_load;
  logic [SEL_W-1:0] sel_value;
  logic             host_adv;
  logic             dma_adv;
  logic             start;
  logic [63:0]      start_ptr;
  logic             busy;

  cfg_item_rom #(
    .N_ITEMS(N_ITEMS), .LEN_STEP(LEN_STEP), .SEL_W(SEL_W), .OFF_W(OFF_W)
  ) u_rom (
    .sel(cur_sel), .off(cur_off), .item_len(item_len),
    .item_byte(item_byte), .in_range(cur_valid)
  );

  cfg_item_cursor #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(sel_load), .load_sel(sel_value),
    .adv(host_adv | dma_adv), .sel(cur_sel), .off(cur_off)
  );

  cfg_host_port #(.SEL_W(SEL_W)) u_host (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .busy(busy),
    .cur_byte(item_byte), .cur_valid(cur_valid), .sel_load(sel_load),
    .sel_value(sel_value), .adv(host_adv), .start(start),
    .start_ptr(start_ptr), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  cfg_dma_xfer #(.OFF_W(OFF_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .item_len(item_len), .cur_off(cur_off), .item_byte(item_byte),
    .adv(dma_adv), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk
  import cfg_dma_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic             host_re,
  input logic [4:0]       host_addr,
  input logic             host_rvalid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [63:0]      mem_req_addr,
  input logic [7:0]       mem_req_wdata,
  input logic             mem_rsp_ready,
  input logic             busy,
  input logic             host_adv,
  input logic             dma_adv,
  input logic [SEL_W-1:0] cur_sel
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  p_rvalid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_re |=> host_rvalid);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == RA_PTR && !busy) |=> busy);

  p_rsp_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  p_single_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_adv, dma_adv}));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
       && $stable(mem_req_wdata)));

  p_busy_sel_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> $stable(cur_sel));
endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
  .host_addr(host_addr), .host_rvalid(host_rvalid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_ready(mem_rsp_ready),
  .busy(busy), .host_adv(host_adv), .dma_adv(dma_adv), .cur_sel(cur_sel)
);

// File: tb/tb_cfg_dma_engine.sv
`timescale 1ns/1ps
module tb_cfg_dma_engine;
  localparam logic [4:0] A_DATA = 5'h00, A_SEL = 5'h08, A_PTR = 5'h0A, A_STAT = 5'h12;
  localparam int DESC = 'h100;
  localparam int NV = 7;
  localparam int V_SEL [NV] = '{1, 2, 0, 3, 0, 1, 7};
  localparam int V_PRE [NV] = '{0, 3, 2, 0, 5, 0, 0};
  localparam int V_TGT [NV] = '{'h10, 'h40, 0, 'h80, 'h20, 'h60, 'h30};
  localparam int V_LEN [NV] = '{5, 8, 4, 4, 6, 0, 1};
  localparam int V_CTL [NV] = '{2, 2, 2, 5, 2, 2, 2};
  localparam int V_BP  [NV] = '{0, 1, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [4:0] host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic host_rvalid;
  logic mem_req_valid, mem_req_we, mem_rsp_ready;
  logic [63:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = '0;
  logic bp_en = 1'b0, tick = 1'b0;
  logic mem_req_ready;

  logic [7:0] mem [0:511];
  int wr_cnt = 0;
  int hold_viol = 0;
  int checks = 0, fails = 0;
  logic hold_prev = 1'b0;
  logic [63:0] hold_addr;
  logic [7:0] hold_data;
  logic hold_we;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  assign mem_req_ready = bp_en ? tick : 1'b1;

  cfg_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data)
  );

  // memory model: one-cycle read response, held until taken
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[8:0]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[8:0]];
      end
    end else if (mem_rsp_valid && mem_rsp_ready) begin
      mem_rsp_valid <= 1'b0;
    end
  end

  // R10 monitor: a stalled request must reappear unchanged
  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_prev && !(mem_req_valid && mem_req_addr == hold_addr &&
                         mem_req_we == hold_we && mem_req_wdata == hold_data))
        hold_viol <= hold_viol + 1;
      hold_prev <= mem_req_valid && !mem_req_ready;
      hold_addr <= mem_req_addr;
      hold_we   <= mem_req_we;
      hold_data <= mem_req_wdata;
    end
  end

  function automatic int ilen(int s);
    return (s >= 0 && s < 4) ? 8 * (s + 1) : 0;
  endfunction

  function automatic logic [7:0] ibyte(int s, int k);
    return 8'((16 * s + 3 * k + 1) % 256);
  endfunction

  function automatic logic [63:0] bswap(logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[63-8*i -: 8];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 2000; i++) begin
      host_read(A_STAT, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic put_desc(logic [63:0] tgt, logic [31:0] len, logic [31:0] ctl);
    logic [127:0] v;
    v = {tgt, len, ctl};
    for (int i = 0; i < 16; i++) mem[DESC + i] = v[127-8*i -: 8];
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
  endtask

  task automatic get_desc(output logic [63:0] a, output logic [31:0] l, output logic [31:0] c);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[127-8*i -: 8] = mem[DESC + i];
    {a, l, c} = v;
  endtask

  task automatic run_job(int sel, int pre, int tgt, int len, int ctl, int bp);
    logic [63:0] d, ra;
    logic [31:0] rl, rc;
    int avail, n, err, w0, bad, nxt;
    put_desc(64'(tgt), 32'(len), 32'(ctl));
    host_write(A_SEL, 64'(sel));
    for (int i = 0; i < pre; i++) host_read(A_DATA, d);
    avail = (ilen(sel) > pre) ? ilen(sel) - pre : 0;
    if (ctl != 2) begin n = 0; err = 1; end
    else if (len > avail) begin n = avail; err = 1; end
    else begin n = len; err = 0; end
    w0 = wr_cnt;
    bp_en = bp[0];
    host_write(A_PTR, bswap(64'(DESC)));
    wait_idle();
    bp_en = 1'b0;
    get_desc(ra, rl, rc);
    chk("R3/R4/R7/R8/R9 control", 64'(rc), err ? 64'd1 : 64'd0);
    chk("R7/R8/R9 address", ra, (tgt == 0) ? 64'd0 : 64'(tgt + n));
    chk("R7/R8/R9 length", 64'(rl), 64'(len - n));
    bad = 0;
    if (tgt != 0) begin
      for (int i = 0; i < n; i++) if (mem[tgt + i] !== ibyte(sel, pre + i)) bad++;
      if (mem[tgt + n] !== 8'hEE) bad++;
    end
    chk("R5 copied bytes", 64'(bad), 64'd0);
    chk("R4/R6/R12 write count", 64'(wr_cnt - w0), 64'(((tgt == 0) ? 0 : n) + 16));
    nxt = pre + n;
    host_read(A_DATA, d);
    chk("R6/R8/R12 offset after job", d, (nxt < ilen(sel)) ? 64'(ibyte(sel, nxt)) : 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R1)
    chk("R1 no request after reset", 64'(mem_req_valid), 64'd0);
    host_read(A_STAT, d);
    chk("R1 status idle", d, 64'd0);
    host_read(A_DATA, d);
    chk("R1/R2 item 0 offset 0", d, 64'(ibyte(0, 0)));
    // byte reads and end of item (R2)
    host_write(A_SEL, 64'd0);
    for (int k = 0; k < 8; k++) begin
      host_read(A_DATA, d);
      chk("R2 item byte", d, 64'(ibyte(0, k)));
    end
    host_read(A_DATA, d);
    chk("R2 past end reads 0", d, 64'd0);
    host_write(A_SEL, 64'd3);
    host_read(A_DATA, d);
    chk("R2 selector resets offset", d, 64'(ibyte(3, 0)));
    // vector table
    for (int v = 0; v < NV; v++)
      run_job(V_SEL[v], V_PRE[v], V_TGT[v], V_LEN[v], V_CTL[v], V_BP[v]);
    // host accesses while busy are ignored (R11)
    put_desc(64'h50, 32'd6, 32'd2);
    host_write(A_SEL, 64'd2);
    bp_en = 1'b1;
    host_write(A_PTR, bswap(64'(DESC)));
    host_write(A_SEL, 64'd3);
    host_read(A_DATA, d);
    chk("R11 data read while busy", d, 64'd0);
    host_write(A_PTR, bswap(64'h180));
    wait_idle();
    bp_en = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 6; i++) if (mem['h50 + i] !== ibyte(2, i)) bad++;
      chk("R11 job unaffected", 64'(bad), 64'd0);
    end
    host_read(A_DATA, d);
    chk("R11 selector and offset kept", d, 64'(ibyte(2, 6)));
    host_read(A_STAT, d);
    chk("R11 second start ignored", d, 64'd0);
    chk("R10 stalled requests held", 64'(hold_viol), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule